// File: doc/BRIEF.md
# BCD Watchdog Countdown Timer

This block is a watchdog timer whose period is programmed as a four-digit packed BCD value. One byte holds hundredths of a second and the other holds whole seconds, so the longest period is 99.99 s. A host reaches the two reload bytes and two control bytes through a simple byte-wide register bus. Counting advances once per pulse on an external 100 Hz enable input. The divider that makes this pulse lives outside the block.

The count is held and decremented directly in BCD, with a borrow from the hundredths byte into the seconds byte. When the count runs out, an expiry flag is set and the count reloads. A steering bit then picks the action. Either a fixed-length reset pulse is issued, or an interrupt line is raised and held until the host reads the status register. Any write to a reload byte restarts the countdown. A reload value of zero stops counting altogether.

Top module: `bcd_wdt`

## Requirements
- R1: Register offsets:
  - Offset 0xC reads the live hundredths byte of the count.
  - Offset 0xD reads the live seconds byte of the count.
  - Offset 0xE is status; its bit 1 reads the expiry flag.
  - Offset 0xF is control; bit 1 is enable and bit 0 is steer, and it reads back as {6'b0, enable, steer}.
  - Every other offset reads 0x00.
- R2: A write to offset 0xC or 0xD stores that reload byte. On the same clock edge, the whole count is loaded from both reload bytes. The new value reads back in the next cycle.
- R3: With enable set and a nonzero reload, each tick lowers the count by one hundredth in packed BCD. A hundredths digit pair of 00 borrows from the seconds byte (for example, 01.00 becomes 00.99).
- R4: A tick that finds the count at 00.01 expires the timer. It sets the expiry flag and reloads the count from the reload bytes, so the period is exactly the reload value in ticks.
- R5: With steer clear, expiry raises the interrupt output. The output stays high until status (0xE) is read.
- R6: With steer set, expiry drives the reset output high for exactly RST_CYCLES clocks and leaves the interrupt output low.
- R7: A status read returns the flag and clears both the flag and the interrupt. An expiry on the same clock as the read wins, leaving both set.
- R8: With enable clear, ticks leave the count unchanged.
- R9: A reload value of 00.00 keeps the count at zero, and no expiry occurs even with enable set.
- R10: After reset, all registers read zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_100hz | input | 1 | One-clock enable pulse at 100 Hz |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a status read clears the flag) |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| wdt_irq | output | 1 | Expiry interrupt, held until status is read |
| wdt_rst | output | 1 | Expiry reset pulse, RST_CYCLES clocks long |

## Verification
The bench builds the block with RST_CYCLES = 3, so the reset pulse length can be counted clock by clock with a short window. It also uses ADDR_W = 5, which brings offsets above 0xF within reach and shows that they neither alias the registers nor read back nonzero. Because the tick is a bench-driven input, every borrow pattern, each expiry path, and the read-versus-expiry collision can be reached in a handful of ticks instead of real seconds.

// File: rtl/bcd_wdt_pkg.sv
// Package: shared offsets, widths and control type for the BCD watchdog.
// Assumes a two-byte packed BCD count (four digits).
package bcd_wdt_pkg;
    localparam int COUNT_DIGITS = 4;
    localparam int COUNT_W      = 4 * COUNT_DIGITS;

    localparam int OFS_HUND = 'hC;
    localparam int OFS_SEC  = 'hD;
    localparam int OFS_STAT = 'hE;
    localparam int OFS_CTRL = 'hF;

    localparam int STAT_FLAG_BIT = 1;
    localparam int CTRL_EN_BIT   = 1;
    localparam int CTRL_STEER_BIT = 0;

    typedef struct packed {
        logic en;
        logic steer;
    } wdt_ctrl_t;
endpackage

// File: rtl/bcd_wdt_regs.sv
// Module: register bank for the BCD watchdog.
// Holds the two reload bytes and the control bits. It flags a reload on a
// write to either count byte and decodes the status-read strobe. Read data
// is combinational from bus_addr. Assumes the host writes valid BCD.
module bcd_wdt_regs
    import bcd_wdt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [7:0]          bus_wdata,
    input  logic [COUNT_W-1:0]  count,
    input  logic                flag,
    output logic [COUNT_W-1:0]  reload_q,
    output logic [COUNT_W-1:0]  reload_nxt,
    output logic                load,
    output wdt_ctrl_t           ctrl_q,
    output logic                flag_clr,
    output logic [7:0]          bus_rdata
);
    logic hit_hund, hit_sec, hit_stat, hit_ctrl;

    // Decode the register offset.
    always_comb begin
        hit_hund = (bus_addr == ADDR_W'(OFS_HUND));
        hit_sec  = (bus_addr == ADDR_W'(OFS_SEC));
        hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
        hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    end

    // Merge a write into the reload value that the counter loads on this edge.
    always_comb begin
        reload_nxt = reload_q;
        if (bus_wr && hit_hund) reload_nxt[7:0]  = bus_wdata;
        if (bus_wr && hit_sec)  reload_nxt[15:8] = bus_wdata;
        load     = bus_wr && (hit_hund || hit_sec);
        flag_clr = bus_rd && hit_stat;
    end

    // Store the reload bytes and the control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            ctrl_q   <= '0;
        end else begin
            reload_q <= reload_nxt;
            if (bus_wr && hit_ctrl) begin
                ctrl_q.en    <= bus_wdata[CTRL_EN_BIT];
                ctrl_q.steer <= bus_wdata[CTRL_STEER_BIT];
            end
        end
    end

    // Select read data: live count bytes, status and control.
    always_comb begin
        bus_rdata = 8'h00;
        if (hit_hund)      bus_rdata = count[7:0];
        else if (hit_sec)  bus_rdata = count[15:8];
        else if (hit_stat) bus_rdata[STAT_FLAG_BIT] = flag;
        else if (hit_ctrl) begin
            bus_rdata[CTRL_EN_BIT]    = ctrl_q.en;
            bus_rdata[CTRL_STEER_BIT] = ctrl_q.steer;
        end
    end
endmodule

// File: rtl/bcd_wdt_counter.sv
// Module: packed BCD down-counter.
// A load takes priority over a tick. With active set, each tick takes one
// away with digit-wise borrow. A tick at value one signals expiry and
// reloads. Assumes every digit holds 0-9.
module bcd_wdt_counter #(
    parameter int NDIG = 4,
    localparam int W   = 4 * NDIG
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload_val,
    input  logic         tick,
    input  logic         active,
    output logic [W-1:0] count_q,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [NDIG:0]  borrow;
    logic [W-1:0]   dec_val;

    assign borrow[0] = 1'b1;

    // One borrow stage per BCD digit.
    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        logic [3:0] dig;
        assign dig = count_q[4*g +: 4];
        assign dec_val[4*g +: 4] = !borrow[g] ? dig :
                                   (dig == 4'd0) ? 4'd9 : dig - 4'd1;
        assign borrow[g+1] = borrow[g] && (dig == 4'd0);
    end

    // Expiry when a tick finds the last hundredth.
    assign expire = tick && active && !load && (count_q == ONE);

    // Update the count: load, reload on expiry, or step down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (load)
            count_q <= load_val;
        else if (expire)
            count_q <= reload_val;
        else if (tick && active && count_q != '0)
            count_q <= dec_val;
    end
endmodule

// File: rtl/bcd_wdt_expiry.sv
// Module: expiry action for the watchdog.
// Keeps the sticky expiry flag and the held interrupt, both cleared by a
// status read (expiry wins a tie). Issues a reset pulse of RST_CYCLES
// clocks when steered. Assumes RST_CYCLES >= 1.
module bcd_wdt_expiry #(
    parameter int RST_CYCLES = 8,
    localparam int CNT_W     = $clog2(RST_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic steer,
    input  logic flag_clr,
    output logic flag_q,
    output logic irq_q,
    output logic rst_out
);
    logic [CNT_W-1:0] pulse_cnt;

    // Sticky flag and interrupt, set on expiry and cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (expire)        flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
            if (expire && !steer) irq_q <= 1'b1;
            else if (flag_clr)    irq_q <= 1'b0;
        end
    end

    // Count out the reset pulse length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_cnt <= '0;
        else if (expire && steer)
            pulse_cnt <= CNT_W'(RST_CYCLES);
        else if (pulse_cnt != '0)
            pulse_cnt <= pulse_cnt - 1'b1;
    end

    assign rst_out = (pulse_cnt != '0);
endmodule

// File: rtl/bcd_wdt.sv
// Module: top of the BCD watchdog countdown timer.
// Ties the register bank, the BCD counter and the expiry logic together.
// Assumes tick_100hz is a one-clock pulse from an outside divider.
module bcd_wdt
    import bcd_wdt_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int RST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_100hz,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              wdt_irq,
    output logic              wdt_rst
);
    logic [COUNT_W-1:0] count, reload_q, reload_nxt;
    logic               load, flag_clr, flag, expire, active;
    logic               en_s, steer_s;
    wdt_ctrl_t          ctrl_q;

    assign en_s    = ctrl_q.en;
    assign steer_s = ctrl_q.steer;
    // A zero reload value keeps the countdown stopped.
    assign active  = en_s && (reload_q != '0);

    bcd_wdt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .count(count),
        .flag(flag), .reload_q(reload_q), .reload_nxt(reload_nxt),
        .load(load), .ctrl_q(ctrl_q), .flag_clr(flag_clr),
        .bus_rdata(bus_rdata)
    );

    bcd_wdt_counter #(.NDIG(COUNT_DIGITS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(reload_nxt),
        .reload_val(reload_q), .tick(tick_100hz), .active(active),
        .count_q(count), .expire(expire)
    );

    bcd_wdt_expiry #(.RST_CYCLES(RST_CYCLES)) u_exp (
        .clk(clk), .rst_n(rst_n), .expire(expire), .steer(steer_s),
        .flag_clr(flag_clr), .flag_q(flag), .irq_q(wdt_irq),
        .rst_out(wdt_rst)
    );
endmodule

// File: rtl/bcd_wdt_chk.sv
// Module: assertion checker for bcd_wdt, attached with bind below.
// Observes the bus strobes, the count, the reload value and the expiry path.
module bcd_wdt_chk #(
    parameter int RST_CYCLES = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        load,
    input logic [15:0] count,
    input logic [15:0] reload_q,
    input logic [15:0] reload_nxt,
    input logic        en,
    input logic        steer,
    input logic        expire,
    input logic        flag,
    input logic        flag_clr,
    input logic        irq,
    input logic        rst_out
);
    int rst_run;

    // Track how many clocks in a row the reset output has been high.
    always_ff @(posedge clk) begin
        if (!rst_n)       rst_run <= 0;
        else if (rst_out) rst_run <= rst_run + 1;
        else              rst_run <= 0;
    end

    // R2
    load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(reload_nxt)));
    // R8
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(count));
    // R9
    zero_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_q == 16'h0000) |-> !expire);
    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);
    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !flag_clr) |=> irq);
    // R6
    rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_run <= RST_CYCLES);
    // R6
    steer_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && steer && !irq) |=> !irq);
endmodule

bind bcd_wdt bcd_wdt_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .load(load), .count(count),
    .reload_q(reload_q), .reload_nxt(reload_nxt), .en(en_s),
    .steer(steer_s), .expire(expire), .flag(flag), .flag_clr(flag_clr),
    .irq(wdt_irq), .rst_out(wdt_rst)
);

// File: tb/bcd_wdt_bench.sv
// Bench: a vector table of reload/tick/expected-count entries, then directed
// tests for reset, expiry paths and corner cases.
module bcd_wdt_bench;
    localparam int AW   = 5;
    localparam int RSTC = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq, rst_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bcd_wdt #(.ADDR_W(AW), .RST_CYCLES(RSTC)) u_bcd_wdt (
        .clk(clk), .rst_n(rst_n), .tick_100hz(tick), .bus_wr(wr),
        .bus_rd(rd), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .wdt_irq(irq), .wdt_rst(rst_o)
    );

    // {hund, sec, ticks, expected hund, expected sec}
    localparam logic [39:0] VEC [6] = '{
        {8'h00, 8'h01, 8'd1, 8'h99, 8'h00},
        {8'h25, 8'h00, 8'd5, 8'h20, 8'h00},
        {8'h10, 8'h00, 8'd1, 8'h09, 8'h00},
        {8'h00, 8'h10, 8'd1, 8'h99, 8'h09},
        {8'h99, 8'h99, 8'd2, 8'h97, 8'h99},
        {8'h00, 8'h00, 8'd3, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk); rd = 1'b1; addr = a; #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        logic [7:0] v;
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check("R10 irq", {7'b0, irq}, 8'h00);
        check("R10 rst", {7'b0, rst_o}, 8'h00);
        bus_read(5'h0C, v); check("R10 hund", v, 8'h00);
        bus_read(5'h0F, v); check("R10 ctrl", v, 8'h00);

        // R1 control readback and unmapped offsets
        bus_write(5'h0F, 8'h02);
        bus_read(5'h0F, v); check("R1 ctrl", v, 8'h02);
        bus_read(5'h03, v); check("R1 unmapped low", v, 8'h00);
        bus_write(5'h1C, 8'h42);
        bus_read(5'h1C, v); check("R1 unmapped high", v, 8'h00);
        bus_read(5'h0C, v); check("R1 no alias", v, 8'h00);

        // R2 R3 vector table: reload, tick, read live count
        foreach (VEC[i]) begin
            bus_write(5'h0C, VEC[i][39:32]);
            bus_write(5'h0D, VEC[i][31:24]);
            ticks(int'(VEC[i][23:16]));
            bus_read(5'h0C, v); check("R3 vec hund", v, VEC[i][15:8]);
            bus_read(5'h0D, v); check("R3 vec sec", v, VEC[i][7:0]);
        end

        // R9 zero reload with enable set: no expiry
        bus_read(5'h0E, v); check("R9 flag", v, 8'h00);
        check("R9 irq", {7'b0, irq}, 8'h00);

        // R2 write restarts the countdown
        bus_write(5'h0D, 8'h00);
        bus_write(5'h0C, 8'h05);
        ticks(2);
        bus_read(5'h0C, v); check("R2 mid", v, 8'h03);
        bus_write(5'h0C, 8'h05);
        bus_read(5'h0C, v); check("R2 restart", v, 8'h05);

        // R8 disabled: ticks ignored
        bus_write(5'h0F, 8'h00);
        bus_write(5'h0C, 8'h50);
        ticks(5);
        bus_read(5'h0C, v); check("R8 hold", v, 8'h50);

        // R4 R5 interrupt path
        bus_write(5'h0F, 8'h02);
        bus_write(5'h0C, 8'h03);
        ticks(2);
        check("R4 not yet", {7'b0, irq}, 8'h00);
        ticks(1);
        check("R5 irq set", {7'b0, irq}, 8'h01);
        check("R6 no rst", {7'b0, rst_o}, 8'h00);
        bus_read(5'h0C, v); check("R4 reload", v, 8'h03);
        bus_read(5'h0E, v); check("R7 flag read", v, 8'h02);
        check("R7 irq cleared", {7'b0, irq}, 8'h00);
        bus_read(5'h0E, v); check("R7 flag cleared", v, 8'h00);

        // R7 expiry on the same clock as a status read wins
        bus_write(5'h0C, 8'h01);
        @(negedge clk); tick = 1'b1; rd = 1'b1; addr = 5'h0E;
        @(negedge clk); tick = 1'b0; rd = 1'b0;
        check("R7 tie irq", {7'b0, irq}, 8'h01);
        bus_read(5'h0E, v); check("R7 tie flag", v, 8'h02);

        // R6 reset path: pulse of RSTC clocks, no interrupt
        bus_write(5'h0F, 8'h03);
        bus_write(5'h0C, 8'h02);
        ticks(1);
        check("R6 no early rst", {7'b0, rst_o}, 8'h00);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        hi = 0;
        for (int k = 0; k < 6; k++) begin
            if (rst_o) hi++;
            @(negedge clk);
        end
        check("R6 pulse len", 8'(hi), 8'(RSTC));
        check("R6 irq low", {7'b0, irq}, 8'h00);
        bus_read(5'h0E, v); check("R4 flag on reset path", v, 8'h02);

        summary();
    end
endmodule